// File: doc/BRIEF.md
# Serial Flash Read Responder

This block is the device side of a multi-line serial NOR flash, restricted to the memory read commands. A host pulls the active-low select low, clocks an 8-bit command code onto the data lines, then a 24-bit start address, and after a command-specific number of idle (dummy) clocks the block streams bytes out of a small internal array. Each read command fixes three things: how many lines carry the address, how many lines carry the data, and how many dummy clocks come before the data.

The array is a register file of `DEPTH` bytes. It is filled through a parallel load port that is sampled on the rising serial clock. The address is taken modulo `DEPTH` and advances by one after each byte, wrapping from the top location back to zero, so one command can stream the whole array as many times as the host keeps clocking. Double-rate command codes, unknown codes and a malformed word-read are refused. For these the block keeps every output enable low until select is released.

Top module: `sflash_rd_resp`

## Requirements
- R1: While `rst_n` is low or `cs_n` is high, `io_oe` is 0000.
- R2: After `cs_n` falls, the command code is sampled on `io_i[0]` on 8 rising `sclk` edges, MSB first. Next come the 24 address bits, MSB first: for 03h, 0Bh, 3Bh and 6Bh one bit per edge on `io_i[0]`; for BBh two bits per edge as {`io_i[1]`,`io_i[0]`}; for EBh and E7h four bits per edge as `io_i[3:0]`.
- R3: The number of dummy rising edges after the address is 0 for 03h, `DMY_FAST` (8) for 0Bh, 3Bh and 6Bh, `DMY_DUAL_IO` (4) for BBh, `DMY_QUAD_IO` (10) for EBh, and exactly 4 for E7h. The first data bits appear on the falling edge that follows the last address or dummy rising edge.
- R4: Data is sent MSB first and changes on falling `sclk` edges. For 03h and 0Bh one bit goes out per clock on `io_o[1]` with `io_oe`=0010. For 3Bh and BBh two bits go out as {`io_o[1]`,`io_o[0]`} with `io_oe`=0011. For 6Bh, EBh and E7h four bits go out as `io_o[3:0]` with `io_oe`=1111.
- R5: The first byte comes from the address modulo `DEPTH`. Each later byte comes from the next location, and `DEPTH`-1 is followed by 0.
- R6: An E7h command whose address bit 0 is 1 is refused, and `io_oe` stays 0000 until `cs_n` rises.
- R7: Command codes 0Dh, 3Dh, BDh, 6Dh, EDh and any code not listed in R2 are refused, and `io_oe` stays 0000 until `cs_n` rises.
- R8: Raising `cs_n` at any moment, including mid-byte or mid-address, clears `io_oe` at once without waiting for a clock edge. The next fall of `cs_n` starts a new command.
- R9: With `ld_en` high on a rising `sclk` edge, `ld_data` is written to location `ld_addr`, and later reads return it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock; input sampled on rise, output changed on fall |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select; high aborts any command |
| io_i | input | 4 | Data lines as seen by the device |
| io_o | output | 4 | Data lines driven by the device |
| io_oe | output | 4 | Per-line output enable |
| ld_en | input | 1 | Array load strobe |
| ld_addr | input | AW | Array load location |
| ld_data | input | 8 | Array load byte |

## Verification
The hardest cases to reach from the ports are a select release that lands between two bits of a byte, and a word read refused only by its very last address nibble. The stimulus steps through every serial clock itself, so it can raise select a chosen number of falling edges into the data or address phase and then check the enables a nanosecond later. For the word-read refusal it sends an address whose final quad slice has its low bit set. A scoreboard expects nothing in both cases, so any byte that leaks out is reported as unexpected. The same run then starts a clean command straight away, which shows that no partial state carries over.

// File: rtl/sflash_rd_resp.sv
module sflash_rd_resp #(
  parameter int DEPTH       = 64,
  parameter int DMY_FAST    = 8,
  parameter int DMY_DUAL_IO = 4,
  parameter int DMY_QUAD_IO = 10,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          sclk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic [3:0]    io_i,
  output logic [3:0]    io_o,
  output logic [3:0]    io_oe,
  input  logic          ld_en,
  input  logic [AW-1:0] ld_addr,
  input  logic [7:0]    ld_data
);

  typedef enum logic [2:0] {S_CMD, S_ADR, S_DMY, S_DAT, S_OFF} st_t;

  localparam logic [4:0] DMY_WORD = 5'd4;

  logic [7:0]    mem [DEPTH];
  wire           kill = !rst_n || cs_n;

  st_t           st;
  logic [4:0]    cnt;
  logic [6:0]    opc;
  logic [AW-1:0] adr;
  logic [2:0]    al, dl;
  logic [4:0]    dmy;
  logic          word;

  logic          dec_ok, dec_word;
  logic [2:0]    dec_al, dec_dl;
  logic [4:0]    dec_dmy;
  logic [AW-1:0] adr_nx;
  logic [4:0]    adr_end;

  always_ff @(posedge sclk)
    if (ld_en) mem[ld_addr] <= ld_data;

  always_comb begin
    dec_ok = 1'b1; dec_al = 3'd1; dec_dl = 3'd1; dec_dmy = 5'd0; dec_word = 1'b0;
    case ({opc, io_i[0]})
      8'h03: ;
      8'h0B: dec_dmy = 5'(DMY_FAST);
      8'h3B: begin dec_dl = 3'd2; dec_dmy = 5'(DMY_FAST); end
      8'h6B: begin dec_dl = 3'd4; dec_dmy = 5'(DMY_FAST); end
      8'hBB: begin dec_al = 3'd2; dec_dl = 3'd2; dec_dmy = 5'(DMY_DUAL_IO); end
      8'hEB: begin dec_al = 3'd4; dec_dl = 3'd4; dec_dmy = 5'(DMY_QUAD_IO); end
      8'hE7: begin dec_al = 3'd4; dec_dl = 3'd4; dec_dmy = DMY_WORD; dec_word = 1'b1; end
      default: dec_ok = 1'b0;
    endcase
  end

  always_comb begin
    case (al)
      3'd4:    begin adr_nx = (adr << 4) | AW'(io_i);      adr_end = 5'd5;  end
      3'd2:    begin adr_nx = (adr << 2) | AW'(io_i[1:0]); adr_end = 5'd11; end
      default: begin adr_nx = (adr << 1) | AW'(io_i[0]);   adr_end = 5'd23; end
    endcase
  end

  always_ff @(posedge sclk or posedge kill) begin
    if (kill) begin
      st <= S_CMD; cnt <= '0; opc <= '0; adr <= '0;
      al <= 3'd1; dl <= 3'd1; dmy <= '0; word <= 1'b0;
    end else begin
      case (st)
        S_CMD: begin
          opc <= {opc[5:0], io_i[0]};
          cnt <= cnt + 5'd1;
          if (cnt == 5'd7) begin
            cnt <= '0;
            if (dec_ok) begin
              st <= S_ADR; al <= dec_al; dl <= dec_dl; dmy <= dec_dmy; word <= dec_word;
            end else st <= S_OFF;
          end
        end
        S_ADR: begin
          adr <= adr_nx;
          cnt <= cnt + 5'd1;
          if (cnt == adr_end) begin
            cnt <= '0;
            if (word && io_i[0]) st <= S_OFF;
            else if (dmy == 5'd0) st <= S_DAT;
            else st <= S_DMY;
          end
        end
        S_DMY: begin
          cnt <= cnt + 5'd1;
          if (cnt == dmy - 5'd1) st <= S_DAT;
        end
        default: ;
      endcase
    end
  end

  logic          act;
  logic [7:0]    sh;
  logic [2:0]    bcnt;
  logic [AW-1:0] ptr;
  wire  [AW-1:0] src = act ? ptr : adr;
  wire  [2:0]    blast = (dl == 3'd4) ? 3'd1 : (dl == 3'd2) ? 3'd3 : 3'd7;

  always_ff @(negedge sclk or posedge kill) begin
    if (kill) begin
      act <= 1'b0; sh <= '0; bcnt <= '0; ptr <= '0;
    end else if (st == S_DAT) begin
      if (!act || bcnt == blast) begin
        sh   <= mem[src];
        ptr  <= (src == AW'(DEPTH - 1)) ? '0 : src + AW'(1);
        bcnt <= '0;
        act  <= 1'b1;
      end else begin
        sh   <= (dl == 3'd4) ? {sh[3:0], 4'b0} : (dl == 3'd2) ? {sh[5:0], 2'b0} : {sh[6:0], 1'b0};
        bcnt <= bcnt + 3'd1;
      end
    end
  end

  assign io_o  = (dl == 3'd4) ? sh[7:4] : (dl == 3'd2) ? {2'b00, sh[7:6]} : {2'b00, sh[7], 1'b0};
  assign io_oe = !act ? 4'b0000 : (dl == 3'd4) ? 4'b1111 : (dl == 3'd2) ? 4'b0011 : 4'b0010;

  p_idle_quiet_r1: assert property (@(posedge sclk) disable iff (!rst_n)
    cs_n |-> io_oe == 4'b0000);

  p_oe_shape_r4: assert property (@(posedge sclk) disable iff (kill)
    io_oe inside {4'b0000, 4'b0010, 4'b0011, 4'b1111});

  p_oe_data_only_r3: assert property (@(posedge sclk) disable iff (kill)
    st != S_DAT |-> io_oe == 4'b0000);

  p_refuse_hold_r7: assert property (@(posedge sclk) disable iff (kill)
    st == S_OFF |=> st == S_OFF && io_oe == 4'b0000);

  p_stream_hold_r5: assert property (@(posedge sclk) disable iff (kill)
    st == S_DAT |=> st == S_DAT);

endmodule

// File: tb/tb_sflash_rd_resp.sv
module tb_sflash_rd_resp;
  localparam int DEPTH = 64;
  localparam int AW = $clog2(DEPTH);

  logic sclk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, ld_en = 1'b0;
  logic [3:0] io_i = '0;
  logic [AW-1:0] ld_addr = '0;
  logic [7:0] ld_data = '0;
  logic [3:0] io_o, io_oe;

  sflash_rd_resp #(.DEPTH(DEPTH)) dut (
    .sclk(sclk), .rst_n(rst_n), .cs_n(cs_n), .io_i(io_i), .io_o(io_o), .io_oe(io_oe),
    .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data));

  always #4 sclk = ~sclk;

  int total = 0, bad = 0;
  logic [7:0] mdl [DEPTH];
  logic [11:0] q [$];
  string cur_tag = "R1";
  bit seen = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge sclk); #1;
  endtask

  initial begin : monitor
    logic [7:0] acc;
    int nb;
    logic [11:0] e;
    acc = '0; nb = 0;
    forever begin
      @(negedge sclk); #3;
      if (cs_n) nb = 0;
      else if (io_oe != 4'b0000) begin
        seen = 1;
        case (io_oe)
          4'b0010: begin acc = {acc[6:0], io_o[1]};   nb += 1; end
          4'b0011: begin acc = {acc[5:0], io_o[1:0]}; nb += 2; end
          4'b1111: begin acc = {acc[3:0], io_o};      nb += 4; end
          default: begin chk(0, "R4", 32'(io_oe), 32'hF); nb = 0; end
        endcase
        if (nb >= 8) begin
          nb = 0;
          if (q.size() == 0) chk(0, cur_tag, {20'h0, io_oe, acc}, 32'hFFFF);
          else begin
            e = q.pop_front();
            chk(e == {io_oe, acc}, cur_tag, {20'h0, io_oe, acc}, {20'h0, e});
          end
        end
      end
    end
  end

  task automatic load(input int a, input logic [7:0] d);
    tick; ld_en = 1'b1; ld_addr = AW'(a); ld_data = d; mdl[a] = d;
    tick; ld_en = 1'b0;
  endtask

  // mode 0: served read, mode 1: refused command
  task automatic run(input logic [7:0] op, input logic [23:0] a, input int al, input int dmy,
                     input int dl, input int nby, input int mode, input string tag);
    logic [3:0] oe_e;
    oe_e = (dl == 4) ? 4'b1111 : (dl == 2) ? 4'b0011 : 4'b0010;
    cur_tag = tag; seen = 0;
    if (mode == 0)
      for (int i = 0; i < nby; i++) q.push_back({oe_e, mdl[(int'(a) + i) % DEPTH]});
    tick; cs_n = 1'b0;
    for (int b = 7; b >= 0; b--) begin io_i = {3'b0, op[b]}; tick; end
    for (int t = 0; t < 24 / al; t++) begin
      case (al)
        4:       io_i = a[23 - 4*t -: 4];
        2:       io_i = {2'b0, a[23 - 2*t -: 2]};
        default: io_i = {3'b0, a[23 - t]};
      endcase
      tick;
    end
    io_i = '0;
    repeat (dmy) tick;
    if (mode == 0) repeat (nby * 8 / dl) tick;
    else repeat (40) tick;
    cs_n = 1'b1;
    tick;
    if (mode == 0) chk(q.size() == 0, tag, 32'(q.size()), 0);
    else begin
      chk(!seen, tag, 32'(seen), 0);
      q.delete();
    end
  endtask

  task automatic abort_after(input logic [7:0] op, input int nticks);
    cur_tag = "R8";
    tick; cs_n = 1'b0;
    for (int b = 7; b >= 0; b--) begin io_i = {3'b0, op[b]}; tick; end
    io_i = '0;
    repeat (nticks) tick;
    cs_n = 1'b1;
    #1 chk(io_oe == 4'b0000, "R8", 32'(io_oe), 0);
    tick;
  endtask

  initial begin : watchdog
    #(8 * 150000);
    bad++; total++;
    $display("FAIL watchdog R8 actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge sclk);
    #1 chk(io_oe == 4'b0000, "R1", 32'(io_oe), 0);
    rst_n = 1'b1;
    tick; chk(io_oe == 4'b0000, "R1", 32'(io_oe), 0);

    for (int i = 0; i < DEPTH; i++) load(i, 8'(i * 29 + 7) ^ 8'h5A);  // R9 preload

    run(8'h03, 24'h000005, 1, 0,  1, 4, 0, "R2");
    run(8'h0B, 24'h000123, 1, 8,  1, 3, 0, "R5");
    run(8'h3B, 24'h00000A, 1, 8,  2, 3, 0, "R4");
    run(8'h6B, 24'h00003E, 1, 8,  4, 4, 0, "R5");
    run(8'hBB, 24'h000014, 2, 4,  2, 2, 0, "R3");
    run(8'hEB, 24'h000028, 4, 10, 4, 3, 0, "R3");
    run(8'hE7, 24'h000108, 4, 4,  4, 2, 0, "R3");
    run(8'hE7, 24'h000009, 4, 4,  4, 2, 1, "R6");
    run(8'h0D, 24'h000000, 1, 8,  1, 0, 1, "R7");
    run(8'hED, 24'h000000, 4, 8,  4, 0, 1, "R7");
    run(8'h3D, 24'h000000, 1, 8,  2, 0, 1, "R7");
    run(8'h55, 24'h000000, 1, 0,  1, 0, 1, "R7");

    abort_after(8'h03, 26);
    chk(q.size() == 0, "R8", 32'(q.size()), 0);
    run(8'h0B, 24'h000011, 1, 8, 1, 2, 0, "R8");
    abort_after(8'hEB, 3);
    run(8'hEB, 24'h00002C, 4, 10, 4, 2, 0, "R8");

    run(8'h6B, 24'h00003F, 1, 8, 4, DEPTH + 2, 0, "R5");

    load(3, 8'hC3);
    run(8'h03, 24'h000002, 1, 0, 1, 3, 0, "R9");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule